// File: doc/BRIEF.md
# Shared Buffer RAM Burst Window

This block gives a 16-bit host CPU access to a 64-bit internal buffer RAM through two registers. The CPU first writes a byte address into a pointer register, then reads or writes a data register over and over. Each data-register access moves to the next 16-bit half-word of the RAM. The burst has no length field. It stops as soon as the CPU touches any other register. After that, further data-register accesses need a new pointer write.

The block turns CPU byte addresses into RAM word indices by subtracting the window base of 0x0400 and dividing by eight. On reads, it fetches whole 64-bit words into a holding register and serves half-words from there. On writes, it gathers half-words and commits each word with per-lane enables. A second requester, the transfer engine, shares the same RAM port. A round-robin arbiter grants one requester per cycle. While the CPU side waits for the RAM, it holds its ready output low.

Top module: `buf_window`

## Requirements
- R1: A pointer write to register address 0xC4 keeps write-data bits 14..1 as the pointer; bit 15 and bit 0 are ignored. Reading 0xC4 returns the current pointer with bit 15 and bit 0 at zero. After reset the pointer reads 0.
- R2: The pointer maps to RAM word index (pointer − 0x0400) >> 3, driven on ram_idx_o. Pointer bits 2..1 select the 16-bit lane within the word, and lane 0 is RAM bits 15..0.
- R3: A pointer write outside 0x0400..0x5FFF sets cpu_err_o. While cpu_err_o is set, data-register reads return 0, data-register writes are dropped, and the CPU side makes no RAM access. A later in-range pointer write clears the flag. The flag is 0 after reset.
- R4: On a burst read from data register 0xC6, the block issues one RAM read when the burst starts and one at each word crossing. Each such access completes with exactly one wait cycle when the RAM port is free. Other beats come from the holding register with no wait. The pointer advances by 2 on every beat.
- R5: On a burst write, the beat that fills lane 3 commits the gathered word in one RAM write with all lanes enabled. Earlier beats of the same word do not touch the RAM.
- R6: Any access to a register other than 0xC6 ends the burst. If write lanes are pending, they are committed first, with only the written lanes enabled, and the access waits one cycle for that. Until the next valid pointer write, data-register reads return 0 and data-register writes are ignored.
- R7: When both requesters ask for the RAM in the same cycle, the one that did not win the previous grant wins. After reset the CPU side is favoured.
- R8: cpu_ready_o stays low while the CPU side needs the RAM and is not granted.
- R9: When a burst steps past byte address 0x5FFF, it ends without setting cpu_err_o. Later data reads return 0.
- R10: On the engine port, a request is granted on eng_gnt_o. A granted write updates only the 16-bit lanes set in eng_be_i. Read data appears on eng_rdata_o one cycle after the grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cpu_req_i | input | 1 | CPU register access request, held until ready |
| cpu_we_i | input | 1 | CPU access is a write |
| cpu_addr_i | input | 8 | CPU register address |
| cpu_wdata_i | input | 16 | CPU write data |
| cpu_ready_o | output | 1 | CPU access completes this cycle |
| cpu_rdata_o | output | 16 | CPU read data, valid with ready |
| cpu_err_o | output | 1 | Sticky out-of-window pointer flag |
| eng_req_i | input | 1 | Engine RAM request, held until granted |
| eng_we_i | input | 1 | Engine request is a write |
| eng_idx_i | input | 12 | Engine RAM word index |
| eng_be_i | input | 4 | Engine 16-bit lane enables |
| eng_wdata_i | input | 64 | Engine write word |
| eng_gnt_o | output | 1 | Engine request granted this cycle |
| eng_rdata_o | output | 64 | RAM read data for the engine |
| ram_en_o | output | 1 | RAM access enable |
| ram_we_o | output | 1 | RAM write |
| ram_idx_o | output | 12 | RAM word index |
| ram_be_o | output | 4 | RAM 16-bit lane enables |
| ram_wdata_o | output | 64 | RAM write word |
| ram_rdata_i | input | 64 | RAM read word, one cycle after a read enable |

## Verification
The assertions assume three things about the inputs. The CPU keeps its request, address, direction and write data stable from the cycle it raises the request until the cycle ready is high. The engine keeps its request fields stable until it is granted. The RAM returns read data on the cycle after an enabled read. The bench tasks drive every input on the falling edge and release a request only after the rising edge on which ready or grant was seen. The bench RAM model has a fixed one-cycle read latency. Engine contention is created by raising the engine request in the same half-cycle the CPU access starts, so the arbiter sees a real tie.

// File: rtl/buf_window_pkg.sv
package buf_window_pkg;
  localparam int unsigned CPU_DW    = 16;
  localparam int unsigned RAM_DW    = 64;
  localparam int unsigned ADDR_W    = 15;
  localparam int unsigned REG_AW    = 8;
  localparam int unsigned WIN_LO_I  = 32'h0400;
  localparam int unsigned WIN_END_I = 32'h6000;
  localparam int unsigned LANES     = RAM_DW / CPU_DW;
  localparam int unsigned LANE_W    = $clog2(LANES);
  localparam int unsigned WORD_SH   = $clog2(RAM_DW / 8);
  localparam int unsigned DEPTH     = (WIN_END_I - WIN_LO_I) >> WORD_SH;
  localparam int unsigned IDX_W     = $clog2(DEPTH);
  localparam logic [ADDR_W-1:0] WIN_LO  = ADDR_W'(WIN_LO_I);
  localparam logic [ADDR_W-1:0] WIN_END = ADDR_W'(WIN_END_I);
  localparam logic [REG_AW-1:0] REG_PTR  = 8'hC4;
  localparam logic [REG_AW-1:0] REG_DATA = 8'hC6;

  typedef struct packed {
    logic              en;
    logic              we;
    logic [IDX_W-1:0]  idx;
    logic [LANES-1:0]  be;
    logic [RAM_DW-1:0] wdata;
  } ram_req_t;

  function automatic logic in_window(input logic [ADDR_W-1:0] a);
    return (a >= WIN_LO) && (a < WIN_END);
  endfunction
endpackage

// File: rtl/bw_addr_map.sv
module bw_addr_map
  import buf_window_pkg::*;
(
  input  logic [ADDR_W-1:0] addr_i,
  output logic [IDX_W-1:0]  idx_o,
  output logic [LANE_W-1:0] lane_o
);
  assign idx_o  = IDX_W'((addr_i - WIN_LO) >> WORD_SH);
  assign lane_o = LANE_W'(addr_i >> 1);
endmodule

// File: rtl/bw_arbiter.sv
module bw_arbiter (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cpu_req_i,
  input  logic eng_req_i,
  output logic cpu_gnt_o,
  output logic eng_gnt_o
);
  logic eng_last_q;  // engine won the most recent grant

  assign cpu_gnt_o = cpu_req_i && (!eng_req_i || eng_last_q);
  assign eng_gnt_o = eng_req_i && !cpu_gnt_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     eng_last_q <= 1'b1;
    else if (cpu_gnt_o || eng_gnt_o) eng_last_q <= eng_gnt_o;
  end

  // R7
  gnt_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cpu_gnt_o && eng_gnt_o));
  // R7
  gnt_has_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !((cpu_gnt_o && !cpu_req_i) || (eng_gnt_o && !eng_req_i)));
  // R7
  rr_to_eng_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_req_i && eng_req_i && cpu_gnt_o) ##1 (cpu_req_i && eng_req_i) |-> eng_gnt_o);
  // R7
  rr_to_cpu_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_req_i && eng_req_i && eng_gnt_o) ##1 (cpu_req_i && eng_req_i) |-> cpu_gnt_o);
endmodule

// File: rtl/bw_cpu_window.sv
module bw_cpu_window
  import buf_window_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [REG_AW-1:0] addr_i,
  input  logic [CPU_DW-1:0] wdata_i,
  output logic              ready_o,
  output logic [CPU_DW-1:0] rdata_o,
  output logic              err_o,
  output ram_req_t          ram_req_o,
  input  logic              gnt_i,
  input  logic [RAM_DW-1:0] ram_rdata_i
);
  logic [ADDR_W-1:0] ptr_q, ptr_nxt, new_ptr;
  logic              armed_q, err_q, hold_vld_q, fetch_q;
  logic [RAM_DW-1:0] hold_q, wbuf_q, wr_word, rd_src;
  logic [LANES-1:0]  wbe_q, wr_be;
  logic [IDX_W-1:0]  cur_idx;
  logic [LANE_W-1:0] cur_lane;
  logic              is_data, is_ptr, dwr, drd, flush, last_lane, accept, new_ok;

  bw_addr_map u_map (.addr_i(ptr_q), .idx_o(cur_idx), .lane_o(cur_lane));

  assign is_data   = addr_i == REG_DATA;
  assign is_ptr    = addr_i == REG_PTR;
  assign dwr       = req_i && is_data && we_i && armed_q;
  assign drd       = req_i && is_data && !we_i && armed_q;
  assign flush     = req_i && (|wbe_q) && !dwr;  // pending lanes go out before anything else
  assign last_lane = cur_lane == LANE_W'(LANES - 1);
  assign ptr_nxt   = ptr_q + ADDR_W'(2);
  assign new_ptr   = {wdata_i[ADDR_W-1:1], 1'b0};
  assign new_ok    = in_window(new_ptr);
  assign err_o     = err_q;

  always_comb begin
    wr_word = wbuf_q;
    wr_word[cur_lane*CPU_DW +: CPU_DW] = wdata_i;
    wr_be = wbe_q | (LANES'(1) << cur_lane);
  end

  always_comb begin
    ram_req_o       = '0;
    ram_req_o.idx   = cur_idx;
    ram_req_o.be    = wbe_q;
    ram_req_o.wdata = wbuf_q;
    if (flush) begin
      ram_req_o.en = 1'b1;
      ram_req_o.we = 1'b1;
    end else if (dwr && last_lane) begin
      ram_req_o.en    = 1'b1;
      ram_req_o.we    = 1'b1;
      ram_req_o.be    = wr_be;
      ram_req_o.wdata = wr_word;
    end else if (drd && !hold_vld_q && !fetch_q) begin
      ram_req_o.en = 1'b1;
      ram_req_o.be = '1;
    end
  end

  always_comb begin
    if (!req_i || flush) ready_o = 1'b0;
    else if (dwr)        ready_o = last_lane ? gnt_i : 1'b1;
    else if (drd)        ready_o = hold_vld_q || fetch_q;
    else                 ready_o = 1'b1;
  end
  assign accept = ready_o;

  assign rd_src = hold_vld_q ? hold_q : ram_rdata_i;
  always_comb begin
    if (drd)                rdata_o = rd_src[cur_lane*CPU_DW +: CPU_DW];
    else if (is_ptr && !we_i) rdata_o = CPU_DW'(ptr_q);
    else                    rdata_o = '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q      <= '0;
      armed_q    <= 1'b0;
      err_q      <= 1'b0;
      hold_vld_q <= 1'b0;
      fetch_q    <= 1'b0;
      hold_q     <= '0;
      wbuf_q     <= '0;
      wbe_q      <= '0;
    end else begin
      fetch_q <= ram_req_o.en && !ram_req_o.we && gnt_i;
      if (flush && gnt_i) wbe_q <= '0;
      if (accept) begin
        if (dwr) begin
          wbuf_q[cur_lane*CPU_DW +: CPU_DW] <= wdata_i;
          wbe_q      <= last_lane ? '0 : wr_be;
          hold_vld_q <= 1'b0;
          ptr_q      <= ptr_nxt;
          if (ptr_nxt == WIN_END) armed_q <= 1'b0;
        end else if (drd) begin
          if (fetch_q) hold_q <= ram_rdata_i;
          hold_vld_q <= !last_lane;
          ptr_q      <= ptr_nxt;
          if (ptr_nxt == WIN_END) armed_q <= 1'b0;
        end else if (!is_data) begin
          hold_vld_q <= 1'b0;
          if (is_ptr && we_i) begin
            ptr_q   <= new_ptr;
            armed_q <= new_ok;
            err_q   <= !new_ok;
          end else begin
            armed_q <= 1'b0;
          end
        end
      end
    end
  end

  // R3
  err_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_q |-> !ram_req_o.en);
  // R4
  ptr_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && is_data && armed_q) |=> ptr_q == ADDR_W'($past(ptr_q) + ADDR_W'(2)));
  // R6
  burst_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && !is_data && !(is_ptr && we_i)) |=> !armed_q);
  // R8
  stall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ram_req_o.en && !gnt_i) |-> !ready_o);
  // R9
  idx_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ram_req_o.en |-> ram_req_o.idx < IDX_W'(DEPTH));
endmodule

// File: rtl/buf_window.sv
module buf_window
  import buf_window_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cpu_req_i,
  input  logic              cpu_we_i,
  input  logic [REG_AW-1:0] cpu_addr_i,
  input  logic [CPU_DW-1:0] cpu_wdata_i,
  output logic              cpu_ready_o,
  output logic [CPU_DW-1:0] cpu_rdata_o,
  output logic              cpu_err_o,
  input  logic              eng_req_i,
  input  logic              eng_we_i,
  input  logic [IDX_W-1:0]  eng_idx_i,
  input  logic [LANES-1:0]  eng_be_i,
  input  logic [RAM_DW-1:0] eng_wdata_i,
  output logic              eng_gnt_o,
  output logic [RAM_DW-1:0] eng_rdata_o,
  output logic              ram_en_o,
  output logic              ram_we_o,
  output logic [IDX_W-1:0]  ram_idx_o,
  output logic [LANES-1:0]  ram_be_o,
  output logic [RAM_DW-1:0] ram_wdata_o,
  input  logic [RAM_DW-1:0] ram_rdata_i
);
  ram_req_t cpu_ram, ram_sel;
  logic     cpu_gnt, eng_gnt;

  bw_cpu_window u_cpu (
    .clk_i, .rst_ni,
    .req_i(cpu_req_i), .we_i(cpu_we_i), .addr_i(cpu_addr_i), .wdata_i(cpu_wdata_i),
    .ready_o(cpu_ready_o), .rdata_o(cpu_rdata_o), .err_o(cpu_err_o),
    .ram_req_o(cpu_ram), .gnt_i(cpu_gnt), .ram_rdata_i(ram_rdata_i)
  );

  bw_arbiter u_arb (
    .clk_i, .rst_ni,
    .cpu_req_i(cpu_ram.en), .eng_req_i(eng_req_i),
    .cpu_gnt_o(cpu_gnt), .eng_gnt_o(eng_gnt)
  );

  always_comb begin
    ram_sel = cpu_ram;
    if (eng_gnt) begin
      ram_sel.we    = eng_we_i;
      ram_sel.idx   = eng_idx_i;
      ram_sel.be    = eng_be_i;
      ram_sel.wdata = eng_wdata_i;
    end
    ram_sel.en = cpu_gnt || eng_gnt;
  end

  assign ram_en_o    = ram_sel.en;
  assign ram_we_o    = ram_sel.we;
  assign ram_idx_o   = ram_sel.idx;
  assign ram_be_o    = ram_sel.be;
  assign ram_wdata_o = ram_sel.wdata;
  assign eng_gnt_o   = eng_gnt;
  assign eng_rdata_o = ram_rdata_i;
endmodule

// File: tb/buf_window_bench.sv
module buf_window_bench;
  import buf_window_pkg::*;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic init = 1'b1;
  always #2 clk = ~clk;

  logic        cpu_req = 0, cpu_we = 0;
  logic [7:0]  cpu_addr = '0;
  logic [15:0] cpu_wdata = '0;
  logic        cpu_ready, cpu_err;
  logic [15:0] cpu_rdata;
  logic        eng_req = 0, eng_we = 0;
  logic [11:0] eng_idx = '0;
  logic [3:0]  eng_be = '0;
  logic [63:0] eng_wdata = '0;
  logic        eng_gnt;
  logic [63:0] eng_rdata;
  logic        ram_en, ram_we;
  logic [11:0] ram_idx;
  logic [3:0]  ram_be;
  logic [63:0] ram_wdata;
  logic [63:0] ram_rdata = '0;

  buf_window u_buf_window (
    .clk_i(clk), .rst_ni(rst_n),
    .cpu_req_i(cpu_req), .cpu_we_i(cpu_we), .cpu_addr_i(cpu_addr), .cpu_wdata_i(cpu_wdata),
    .cpu_ready_o(cpu_ready), .cpu_rdata_o(cpu_rdata), .cpu_err_o(cpu_err),
    .eng_req_i(eng_req), .eng_we_i(eng_we), .eng_idx_i(eng_idx), .eng_be_i(eng_be),
    .eng_wdata_i(eng_wdata), .eng_gnt_o(eng_gnt), .eng_rdata_o(eng_rdata),
    .ram_en_o(ram_en), .ram_we_o(ram_we), .ram_idx_o(ram_idx), .ram_be_o(ram_be),
    .ram_wdata_o(ram_wdata), .ram_rdata_i(ram_rdata)
  );

  int checks = 0, fails = 0;
  int rd_cnt = 0, wr_cnt = 0, eng_gnt_cnt = 0;
  logic [11:0] last_rd_idx = '0;
  logic [63:0] mem [0:DEPTH-1];

  function automatic logic [63:0] pat(input int i);
    logic [15:0] v;
    v = 16'(i);
    return {v ^ 16'h5A5A, v + 16'h1234, ~v, v};
  endfunction

  function automatic logic [15:0] ln(input logic [63:0] w, input int k);
    return w[k*16 +: 16];
  endfunction

  always @(posedge clk) begin
    if (init) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= pat(i);
    end else if (ram_en) begin
      if (ram_we) begin
        wr_cnt++;
        for (int k = 0; k < 4; k++)
          if (ram_be[k]) mem[ram_idx][k*16 +: 16] <= ram_wdata[k*16 +: 16];
      end else begin
        rd_cnt++;
        last_rd_idx = ram_idx;
        ram_rdata <= mem[ram_idx];
      end
    end
  end

  always begin
    @(negedge clk);
    #1;
    if (eng_gnt) eng_gnt_cnt++;
  end

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cpu_acc(input logic [7:0] a, input logic we, input logic [15:0] wd,
                         output logic [15:0] rd, output int waits);
    @(negedge clk);
    cpu_req = 1; cpu_we = we; cpu_addr = a; cpu_wdata = wd;
    waits = 0;
    forever begin
      #1;
      if (cpu_ready) begin
        rd = cpu_rdata;
        break;
      end
      waits++;
      @(negedge clk);
    end
    @(posedge clk);
    #1 cpu_req = 0;
  endtask

  task automatic eng_acc(input logic we, input logic [11:0] idx, input logic [3:0] be,
                         input logic [63:0] wd, output logic [63:0] rd);
    @(negedge clk);
    eng_req = 1; eng_we = we; eng_idx = idx; eng_be = be; eng_wdata = wd;
    forever begin
      #1;
      if (eng_gnt) break;
      @(negedge clk);
    end
    @(posedge clk);
    #1 eng_req = 0;
    rd = eng_rdata;
  endtask

  task automatic set_ptr(input logic [15:0] p);
    logic [15:0] d; int w;
    cpu_acc(REG_PTR, 1'b1, p, d, w);
  endtask

  task automatic t_reset();
    logic [15:0] d; int w;
    chk("R8 ready idle after reset", 64'(cpu_ready), 64'h0);
    chk("R3 err after reset", 64'(cpu_err), 64'h0);
    chk("R10 eng_gnt after reset", 64'(eng_gnt), 64'h0);
    chk("R7 ram_en after reset", 64'(ram_en), 64'h0);
    cpu_acc(REG_PTR, 1'b0, 16'h0, d, w);
    chk("R1 pointer after reset", 64'(d), 64'h0);
  endtask

  task automatic t_pointer();
    logic [15:0] d; int w;
    set_ptr(16'h9000);
    cpu_acc(REG_PTR, 1'b0, 16'h0, d, w);
    chk("R1 bit15 ignored", 64'(d), 64'h1000);
    chk("R1 in-range no err", 64'(cpu_err), 64'h0);
    set_ptr(16'h1003);
    cpu_acc(REG_PTR, 1'b0, 16'h0, d, w);
    chk("R1 bit0 ignored", 64'(d), 64'h1002);
  endtask

  task automatic t_read_burst();
    logic [15:0] d; int w; int r0;
    int exp_w [6] = '{1, 0, 0, 0, 1, 0};
    set_ptr(16'h1000);
    r0 = rd_cnt;
    for (int i = 0; i < 6; i++) begin
      cpu_acc(REG_DATA, 1'b0, 16'h0, d, w);
      chk("R4 burst read data", 64'(d), 64'(ln(pat(16'h180 + i / 4), i % 4)));
      chk("R4 burst read waits", 64'(w), 64'(exp_w[i]));
      if (i == 0) chk("R2 word index", 64'(last_rd_idx), 64'h180);
    end
    chk("R4 one fetch per word", 64'(rd_cnt - r0), 64'd2);
    set_ptr(16'h1006);
    cpu_acc(REG_DATA, 1'b0, 16'h0, d, w);
    chk("R2 lane select mid word", 64'(d), 64'(ln(pat(16'h180), 3)));
    cpu_acc(REG_DATA, 1'b0, 16'h0, d, w);
    chk("R4 word crossing", 64'(d), 64'(ln(pat(16'h181), 0)));
    chk("R4 crossing refetch wait", 64'(w), 64'd1);
  endtask

  task automatic t_write_burst();
    logic [15:0] d; int w; int w0;
    set_ptr(16'h2000);
    w0 = wr_cnt;
    for (int i = 0; i < 3; i++) cpu_acc(REG_DATA, 1'b1, 16'(16'h1111 * (i + 1)), d, w);
    chk("R5 no write before lane3", 64'(wr_cnt - w0), 64'd0);
    cpu_acc(REG_DATA, 1'b1, 16'h4444, d, w);
    chk("R5 single commit", 64'(wr_cnt - w0), 64'd1);
    chk("R5 full word", mem[12'h380], 64'h4444_3333_2222_1111);
  endtask

  task automatic t_partial();
    logic [15:0] d; int w; int w0;
    logic [63:0] orig;
    orig = pat(12'h381);
    set_ptr(16'h2008);
    cpu_acc(REG_DATA, 1'b1, 16'hAAAA, d, w);
    cpu_acc(REG_DATA, 1'b1, 16'hBBBB, d, w);
    chk("R5 partial not yet committed", mem[12'h381], orig);
    cpu_acc(REG_PTR, 1'b0, 16'h0, d, w);
    chk("R6 flush wait", 64'(w), 64'd1);
    chk("R6 partial lanes only", mem[12'h381], {orig[63:32], 32'hBBBB_AAAA});
    w0 = wr_cnt;
    cpu_acc(REG_DATA, 1'b1, 16'hCCCC, d, w);
    chk("R6 write after end ignored", 64'(wr_cnt - w0), 64'd0);
    cpu_acc(REG_DATA, 1'b0, 16'h0, d, w);
    chk("R6 read after end is zero", 64'(d), 64'h0);
    set_ptr(16'h2008);
    for (int i = 0; i < 4; i++) begin
      cpu_acc(REG_DATA, 1'b0, 16'h0, d, w);
      chk("R6 word after ended burst", 64'(d),
          64'(ln({orig[63:32], 32'hBBBB_AAAA}, i)));
    end
  endtask

  task automatic t_error();
    logic [15:0] d; int w; int r0, w0;
    set_ptr(16'h0300);
    chk("R3 low pointer sets err", 64'(cpu_err), 64'h1);
    r0 = rd_cnt; w0 = wr_cnt;
    cpu_acc(REG_DATA, 1'b0, 16'h0, d, w);
    chk("R3 blocked read zero", 64'(d), 64'h0);
    cpu_acc(REG_DATA, 1'b1, 16'h5555, d, w);
    chk("R3 no RAM access", 64'(rd_cnt - r0 + wr_cnt - w0), 64'd0);
    set_ptr(16'h6000);
    chk("R3 high pointer err", 64'(cpu_err), 64'h1);
    set_ptr(16'h0400);
    chk("R3 valid pointer clears", 64'(cpu_err), 64'h0);
    cpu_acc(REG_DATA, 1'b0, 16'h0, d, w);
    chk("R3 access after clear", 64'(d), 64'(ln(pat(0), 0)));
  endtask

  task automatic t_top();
    logic [15:0] d; int w;
    set_ptr(16'h5FFC);
    cpu_acc(REG_DATA, 1'b0, 16'h0, d, w);
    chk("R9 last word lane2", 64'(d), 64'(ln(pat(DEPTH - 1), 2)));
    cpu_acc(REG_DATA, 1'b0, 16'h0, d, w);
    chk("R9 last word lane3", 64'(d), 64'(ln(pat(DEPTH - 1), 3)));
    cpu_acc(REG_DATA, 1'b0, 16'h0, d, w);
    chk("R9 past end reads zero", 64'(d), 64'h0);
    chk("R9 no err at end", 64'(cpu_err), 64'h0);
  endtask

  task automatic t_engine();
    logic [63:0] r; logic [15:0] d; int w; int g0;
    logic [63:0] o;
    o = pat(16'h10);
    eng_acc(1'b1, 12'h010, 4'b0101, 64'h1111_2222_3333_4444, r);
    chk("R10 engine lane enables", mem[12'h010], {o[63:48], 16'h2222, o[31:16], 16'h4444});
    eng_acc(1'b0, 12'h180, 4'hF, 64'h0, r);
    chk("R10 engine read latency", r, pat(16'h180));
    // contention: pending lanes force flush then fetch while the engine keeps asking
    set_ptr(16'h3000);
    cpu_acc(REG_DATA, 1'b1, 16'hD00D, d, w);
    cpu_acc(REG_DATA, 1'b1, 16'hF00F, d, w);
    eng_we = 0; eng_idx = 12'h005; eng_be = 4'hF;
    eng_req = 1;
    g0 = eng_gnt_cnt;
    cpu_acc(REG_DATA, 1'b0, 16'h0, d, w);
    eng_req = 0;
    chk("R8 stall while engine wins", 64'(w), 64'd3);
    chk("R7 alternating grants", 64'(eng_gnt_cnt - g0), 64'd2);
    chk("R7 data after contention", 64'(d), 64'(ln(pat(16'h580), 2)));
    chk("R6 flush under contention", mem[12'h580], {pat(16'h580)[63:32], 32'hF00F_D00D});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog all actual=timeout expected=done");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    init = 0;
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    #1;
    t_reset();
    t_pointer();
    t_read_burst();
    t_write_burst();
    t_partial();
    t_error();
    t_top();
    t_engine();
    repeat (2) @(posedge clk);
    summary();
    $finish;
  end
endmodule